// File: doc/BRIEF.md
# Flash Read Request Aligner

This block sits in front of an octal-SPI flash engine and reshapes read requests so they meet the engine's alignment limits. Each request carries a byte address and a byte length. The block emits a downstream request whose range is widened to a chosen granule. The start is rounded down to the granule and the end is rounded up, so the new range always holds every byte that was asked for.

Two static control inputs pick the granule. With `word_align_dis` low, the granule is a 32-bit word, and this setting wins whatever the other input holds. With `word_align_dis` high and `half_align_dis` low, the granule is two bytes. With both inputs high, requests pass through untouched. For each accepted request, the block stores how many padding bytes sit before the requested range and after it. These records queue in a small FIFO, so several requests can be outstanding at once. The flash engine returns data one byte per beat. The block discards the padding beats and hands the requester exactly the bytes it asked for, flagging the last of them.

Top module: `flash_read_aligner`

## Requirements
- R1: With `word_align_dis`=0 and `half_align_dis`=1, `dn_addr` is `req_addr` rounded down to a multiple of 4, and `dn_addr+dn_len` is `req_addr+req_len` rounded up to a multiple of 4.
- R2: With `word_align_dis`=1 and `half_align_dis`=0, `dn_addr` is `req_addr` rounded down to a multiple of 2, and `dn_addr+dn_len` is `req_addr+req_len` rounded up to a multiple of 2.
- R3: With both control inputs at 1, `dn_addr`=`req_addr` and `dn_len`=`req_len`.
- R4: With both control inputs at 0, the 32-bit rule of R1 applies and the 2-byte rule is not used.
- R5: While the tracking FIFO has room, `dn_valid` follows `req_valid` and `req_ready` follows `dn_ready` in the same cycle. A request is taken when `req_valid`, `dn_ready` and room in the FIFO all hold together.
- R6: Returned beats, one byte each and `dn_len` beats per request in request order, are trimmed. The leading and trailing padding beats are dropped, and the kept beats appear on `out_data` in address order, equal to the bytes at `req_addr` .. `req_addr+req_len-1`.
- R7: `out_last` is 1 exactly on the beat carrying the byte at `req_addr+req_len-1`.
- R8: A padding beat is consumed (`rsp_ready`=1) whatever `out_ready` holds. A kept beat waits for `out_ready`: `rsp_ready`=0 and `out_valid`=1 with stable data until `out_ready` is 1.
- R9: Up to `TAG_DEPTH` requests may be outstanding. With that many outstanding, `req_ready`=0 and `dn_valid`=0.
- R10: After reset, with no request outstanding, `rsp_ready`=0 and `out_valid`=0 even when `rsp_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_align_dis | input | 1 | 1 turns off 32-bit widening |
| half_align_dis | input | 1 | 1 turns off 2-byte widening |
| req_valid | input | 1 | Upstream read request valid |
| req_ready | output | 1 | Upstream request accepted |
| req_addr | input | ADDR_W | Requested byte address |
| req_len | input | LEN_W | Requested byte count, at least 1 |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Flash engine takes the request |
| dn_addr | output | ADDR_W | Widened start address |
| dn_len | output | LEN_W+1 | Widened byte count |
| rsp_valid | input | 1 | Returned byte valid |
| rsp_ready | output | 1 | Returned byte consumed |
| rsp_data | input | 8 | Returned byte |
| out_valid | output | 1 | Trimmed byte valid |
| out_ready | input | 1 | Requester takes the trimmed byte |
| out_data | output | 8 | Trimmed byte |
| out_last | output | 1 | Final requested byte of a request |

## Verification
A beat counter that drifts, or a stored offset that is wrong, shows at the ports on the very beat it affects. The data on `out_data` shifts by one or more byte positions, or `out_last` lands on the wrong beat. The error then carries into every later request, because response boundaries stop lining up. A wrong occupancy count in the tracking FIFO shows up in one of two ways: `req_ready` drops too early or too late when the queue fills, or the trimmer stays stalled with `rsp_ready` low. The bench checks every address phase and short length in each mode, a full queue and held back-pressure, so each of these faults appears within a few cycles of the first request it affects.

// File: rtl/fra_pkg.sv
// Shared definitions for the flash read aligner.
// Assumes byte-granular addresses and one byte per returned beat.
package fra_pkg;
    // Widening granule chosen by the two control inputs.
    typedef enum logic [1:0] {
        GRAN_BYTE = 2'd0,
        GRAN_HALF = 2'd1,
        GRAN_WORD = 2'd2
    } gran_e;

    // Width of a padding offset; the largest granule is four bytes.
    localparam int unsigned PAD_W = 2;
endpackage

// File: rtl/fra_calc.sv
// Combinational request widening.
// Picks the granule (32-bit wins over 2-byte), rounds the start down and the
// end up, and reports the leading and trailing pad byte counts.
// Assumes len >= 1 and that the widened range does not wrap the address space.
module fra_calc
    import fra_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 8
) (
    input  logic              word_dis,
    input  logic              half_dis,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [ADDR_W-1:0] wide_addr,
    output logic [LEN_W:0]    wide_len,
    output logic [PAD_W-1:0]  pad_lead,
    output logic [PAD_W-1:0]  pad_trail
);
    gran_e             gran;
    logic [PAD_W-1:0]  mask;
    logic [LEN_W:0]    lead_plus_len;

    // Granule selection with fixed priority of the 32-bit rule.
    always_comb begin
        if (!word_dis)      gran = GRAN_WORD;
        else if (!half_dis) gran = GRAN_HALF;
        else                gran = GRAN_BYTE;
    end

    // Low address bits that the granule clears.
    assign mask = {gran == GRAN_WORD, gran != GRAN_BYTE};

    // Offsets, widened address and widened length.
    always_comb begin
        pad_lead      = addr[PAD_W-1:0] & mask;
        lead_plus_len = (LEN_W+1)'(pad_lead) + (LEN_W+1)'(len);
        pad_trail     = (PAD_W'(0) - lead_plus_len[PAD_W-1:0]) & mask;
        wide_len      = lead_plus_len + (LEN_W+1)'(pad_trail);
        wide_addr     = {addr[ADDR_W-1:PAD_W], addr[PAD_W-1:0] & ~mask};
    end
endmodule

// File: rtl/fra_tag_fifo.sv
// Small FIFO of per-request trim records.
// Assumes DEPTH >= 2; push is never asserted while full, pop never while empty.
module fra_tag_fifo #(
    parameter int unsigned W     = 12,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign pop_data = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/fra_trim.sv
// Response trimmer.
// Counts returned beats of the oldest outstanding request, drops the pad beats
// before and after the requested range, and forwards the rest with a last flag.
// Assumes the engine returns exactly the widened length for each request, in order.
module fra_trim
    import fra_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_empty,
    input  logic [PAD_W-1:0] tag_lead,
    input  logic [LEN_W-1:0] tag_len,
    input  logic [PAD_W-1:0] tag_trail,
    output logic             tag_pop,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [7:0]       rsp_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last
);
    localparam int unsigned CW = LEN_W + 1;

    logic [CW-1:0] beat_idx;
    logic [CW-1:0] keep_end;
    logic [CW-1:0] total;
    logic          in_keep;
    logic          beat;

    // Kept window boundaries for the current record.
    always_comb begin
        keep_end = CW'(tag_lead) + CW'(tag_len);
        total    = keep_end + CW'(tag_trail);
        in_keep  = (beat_idx >= CW'(tag_lead)) && (beat_idx < keep_end);
    end

    // Handshake steering: pad beats drain freely, kept beats follow the sink.
    always_comb begin
        out_valid = !tag_empty && rsp_valid && in_keep;
        rsp_ready = !tag_empty && (in_keep ? out_ready : 1'b1);
        out_data  = rsp_data;
        out_last  = in_keep && (beat_idx == keep_end - 1'b1);
        beat      = rsp_valid && rsp_ready;
        tag_pop   = beat && (beat_idx == total - 1'b1);
    end

    // Beat position within the current response.
    always_ff @(posedge clk) begin
        if (!rst_n)       beat_idx <= '0;
        else if (tag_pop) beat_idx <= '0;
        else if (beat)    beat_idx <= beat_idx + 1'b1;
    end

    assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_empty |-> beat_idx < total);
    assert_idle_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tag_empty |-> beat_idx == '0);
    assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && rsp_valid) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/flash_read_aligner.sv
// Top of the flash read aligner.
// Widens each read request to the selected granule, queues the trim record,
// and trims the returned byte stream back to the requested range.
// Assumes the control inputs are static while requests are outstanding and
// that req_len is at least 1.
module flash_read_aligner
    import fra_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 8,
    parameter int unsigned TAG_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_align_dis,
    input  logic              half_align_dis,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [LEN_W:0]    dn_len,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [7:0]        rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);
    localparam int unsigned TAG_W = 2 * PAD_W + LEN_W;

    logic [PAD_W-1:0] c_lead, c_trail, t_lead, t_trail;
    logic [LEN_W-1:0] t_len;
    logic [TAG_W-1:0] t_word;
    logic             t_full, t_empty, t_push, t_pop;

    fra_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_calc (
        .word_dis  (word_align_dis),
        .half_dis  (half_align_dis),
        .addr      (req_addr),
        .len       (req_len),
        .wide_addr (dn_addr),
        .wide_len  (dn_len),
        .pad_lead  (c_lead),
        .pad_trail (c_trail)
    );

    // Request pass-through gated by room in the record queue.
    always_comb begin
        dn_valid  = req_valid && !t_full;
        req_ready = dn_ready && !t_full;
        t_push    = req_valid && dn_ready && !t_full;
    end

    fra_tag_fifo #(.W(TAG_W), .DEPTH(TAG_DEPTH)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (t_push),
        .push_data ({c_lead, req_len, c_trail}),
        .pop       (t_pop),
        .pop_data  (t_word),
        .full      (t_full),
        .empty     (t_empty)
    );

    assign {t_lead, t_len, t_trail} = t_word;

    fra_trim #(.LEN_W(LEN_W)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .tag_empty (t_empty),
        .tag_lead  (t_lead),
        .tag_len   (t_len),
        .tag_trail (t_trail),
        .tag_pop   (t_pop),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // Range ends, extended by one bit, used only by the checks below.
    logic [ADDR_W:0] req_end, dn_end;
    assign req_end = {1'b0, req_addr} + (ADDR_W+1)'(req_len);
    assign dn_end  = {1'b0, dn_addr} + (ADDR_W+1)'(dn_len);

    assert_word_grain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !word_align_dis) |-> (dn_addr[1:0] == 2'b00 && dn_len[1:0] == 2'b00));
    assert_half_grain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && word_align_dis && !half_align_dis) |-> (!dn_addr[0] && !dn_len[0]));
    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && word_align_dis && half_align_dis) |->
            (dn_addr == req_addr && dn_len == (LEN_W+1)'(req_len)));
    assert_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> ({1'b0, dn_addr} <= {1'b0, req_addr} && dn_end >= req_end
                      && dn_end - req_end < 4));
    assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> dn_valid);
    assert_full_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        t_full |-> (!req_ready && !dn_valid));
endmodule

// File: tb/tb_flash_read_aligner.sv
`timescale 1ns/1ps
module tb_flash_read_aligner;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              word_align_dis = 1'b0, half_align_dis = 1'b0;
    logic              req_valid = 1'b0, dn_ready = 1'b0;
    logic              req_ready, dn_valid;
    logic [ADDR_W-1:0] req_addr = '0, dn_addr;
    logic [LEN_W-1:0]  req_len = '0;
    logic [LEN_W:0]    dn_len;
    logic              rsp_valid = 1'b0, rsp_ready;
    logic [7:0]        rsp_data = '0, out_data;
    logic              out_valid, out_ready = 1'b0, out_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_read_aligner #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .word_align_dis(word_align_dis), .half_align_dis(half_align_dis),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_addr(dn_addr), .dn_len(dn_len),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input longint a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic int gran_of(input bit wd, input bit hd);
        if (!wd) return 4;
        if (!hd) return 2;
        return 1;
    endfunction

    // Issue one request and check the widened form (R1..R5).
    task automatic issue(input bit wd, input bit hd, input longint a, input int n,
                         output longint st, output int dl);
        int     g;
        longint e;
        string  rq;
        g  = gran_of(wd, hd);
        st = a - (a % g);
        e  = ((a + n + g - 1) / g) * g;
        dl = int'(e - st);
        rq = !wd ? (!hd ? "R4" : "R1") : (!hd ? "R2" : "R3");
        @(negedge clk);
        word_align_dis = wd; half_align_dis = hd;
        req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(n); dn_ready = 1'b1;
        #1;
        chk(dn_valid == 1'b1, "R5", dn_valid, 1);
        chk(req_ready == 1'b1, "R5", req_ready, 1);
        chk(longint'(dn_addr) == st, rq, dn_addr, st);
        chk(int'(dn_len) == dl, rq, dn_len, dl);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Return the widened range byte by byte and check the trimmed stream (R6..R8).
    task automatic stream(input longint a, input int n, input longint st, input int dl,
                          input bit stall);
        int ld;
        ld = int'(a - st);
        for (int i = 0; i < dl; i++) begin
            bit keep;
            keep = (i >= ld) && (i < ld + n);
            @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = mem_byte(st + i);
            out_ready = keep && !(stall && i == ld);
            #1;
            if (!keep) begin
                chk(out_valid == 1'b0, "R6", out_valid, 0);
                chk(rsp_ready == 1'b1, "R8", rsp_ready, 1);
            end else begin
                if (stall && i == ld) begin
                    chk(rsp_ready == 1'b0, "R8", rsp_ready, 0);
                    chk(out_valid == 1'b1, "R8", out_valid, 1);
                    @(negedge clk);
                    out_ready = 1'b1;
                    #1;
                end
                chk(out_valid == 1'b1, "R6", out_valid, 1);
                chk(out_data == mem_byte(a + i - ld), "R6", out_data, mem_byte(a + i - ld));
                chk(out_last == (i == ld + n - 1), "R7", out_last, i == ld + n - 1);
                chk(rsp_ready == 1'b1, "R8", rsp_ready, 1);
            end
            @(posedge clk);
        end
        @(negedge clk);
        rsp_valid = 1'b0;
        out_ready = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        longint st;
        int     dl;
        longint sts [DEPTH];
        int     dls [DEPTH];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: idle after reset, returned beats are not taken.
        @(negedge clk);
        rsp_valid = 1'b1; out_ready = 1'b1;
        #1;
        chk(rsp_ready == 1'b0, "R10", rsp_ready, 0);
        chk(out_valid == 1'b0, "R10", out_valid, 0);
        @(negedge clk);
        rsp_valid = 1'b0; out_ready = 1'b0;

        // Sweep: every control setting, address phase and short length.
        for (int m = 0; m < 4; m++) begin
            for (int ph = 0; ph < 8; ph++) begin
                for (int n = 1; n <= 9; n++) begin
                    longint a;
                    a = 64'h1000 + ph;
                    issue(m[0], m[1], a, n, st, dl);
                    stream(a, n, st, dl, (n % 3) == 0);
                end
            end
        end

        // R9: fill the record queue, then check the block refuses more.
        for (int k = 0; k < DEPTH; k++) begin
            issue(1'b0, 1'b1, 64'h2001 + 5 * k, 3 + k, sts[k], dls[k]);
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3000; req_len = 8'd4; dn_ready = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R9", req_ready, 0);
        chk(dn_valid == 1'b0, "R9", dn_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            stream(64'h2001 + 5 * k, 3 + k, sts[k], dls[k], k == 1);
        end
        // R9: queue drained, requests are taken again.
        @(negedge clk);
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R9", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        // Drain the request just accepted (32-bit granule at 0x3000, length 4).
        stream(64'h3000, 4, 64'h3000, 4, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule